// File: doc/BRIEF.md
# Subbanked Slow-Write Memory Array

This block is an on-chip word memory whose cells need many clock cycles to take a new value. The storage is split into subbanks, and the subbank is chosen by the low-order bits of the word address. Each subbank has a one-entry write buffer. An accepted write is parked in the buffer of its subbank, so the shared request port is free again on the next cycle. The subbank then programs the word in the background while the other subbanks keep taking traffic.

Reads use a separate read path into every subbank and are never held up by a write that is in progress. A read of the word that sits in a pending buffer is answered from the buffer. Each write is differential: the subbank records which bits differ from the stored word and programs only those bits. A write that changes no bit never occupies the buffer. The address and data for reads and writes travel on one request with a single valid/ready pair, and a request may carry a read, a write, or both.

Each subbank is run by a two-state machine. In `SB_IDLE` the buffer is empty. The transition *capture* (an accepted write that changes at least one bit) moves it to `SB_PROGRAM` and loads the countdown. The transition *null write* (an accepted write with no changed bit) leaves it in `SB_IDLE`. In `SB_PROGRAM` the countdown runs. The transition *commit* (countdown at zero) writes the changed bits into the array and returns the machine to `SB_IDLE`. Reset forces `SB_IDLE`.

Top module: `sw_subbank_ram`

## Requirements
- R1: The subbank is `req_wr_addr[SBW-1:0]` with `SBW = log2(NSB)`, and the row is the remaining upper bits. A request whose write targets a subbank with an empty buffer is accepted at once (`req_ready` high). Writes to different subbanks on consecutive cycles are all accepted without a stall.
- R2: After a write that changes at least one bit is accepted, `sb_busy` of its subbank is high for exactly `WR_LAT` cycles. Busy periods of different subbanks overlap.
- R3: Once busy has dropped, reads of the written address return the new word.
- R4: A read of the address held in a pending buffer returns the buffered word and not the old array contents.
- R5: A read of another row of a subbank that is busy is accepted without a stall and returns that row's stored word.
- R6: A request whose write targets a busy subbank sees `req_ready` low until that subbank is free. Neither its read nor its write takes effect while it is stalled.
- R7: A write whose data equals the stored word leaves `sb_busy` low, and the stored word is unchanged.
- R8: `rsp_valid` pulses for exactly one cycle, on the cycle after a request carrying a read is accepted, with `rsp_data`. It stays low after a request that carries only a write.
- R9: A read and a write to the same address, accepted together, return the new write data.
- R10: Synchronous active-high reset empties every buffer (all `sb_busy` low), drives `rsp_valid` low, and clears the array to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_wr_en | input | 1 | Request carries a write |
| req_wr_addr | input | AW | Write word address |
| req_wr_data | input | DW | Write data |
| req_rd_en | input | 1 | Request carries a read |
| req_rd_addr | input | AW | Read word address |
| rsp_valid | output | 1 | Read data valid, one cycle after acceptance |
| rsp_data | output | DW | Read data |
| sb_busy | output | NSB | Per-subbank background write in progress |

## Verification
The bench sweeps all 256 addresses of the default configuration. After each write it reads the same address, which must be forwarded from the buffer, and then a different row of the same subbank, which must return the stored word. A design without forwarding would return the old word. A design that blocks reads on a busy subbank would stall those reads. The bench also measures the stall length for a write into a busy subbank and the length of each busy window. An off-by-one countdown would show up as a count that differs from `WR_LAT`. The remaining cases are a rewrite of the stored value, which must not raise busy, and a read and write to the same address in one request, where a design that reads the array would return stale data.

// File: rtl/sw_ram_pkg.sv
package sw_ram_pkg;
    typedef enum logic [0:0] {
        SB_IDLE    = 1'b0,
        SB_PROGRAM = 1'b1
    } sb_state_e;
endpackage

// File: rtl/sw_subbank_cell.sv
module sw_subbank_cell
    import sw_ram_pkg::*;
#(
    parameter int DW     = 16,
    parameter int ROWS   = 64,
    parameter int WR_LAT = 20
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_go,
    input  logic [$clog2(ROWS)-1:0] wr_row,
    input  logic [DW-1:0]           wr_data,
    input  logic [$clog2(ROWS)-1:0] rd_row,
    output logic [DW-1:0]           rd_data,
    output logic                    busy
);
    localparam int RW = $clog2(ROWS);
    localparam int CW = $clog2(WR_LAT + 1);

    logic [DW-1:0] cells [ROWS];
    sb_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [RW-1:0] buf_row_q;
    logic [DW-1:0] buf_data_q;
    logic [DW-1:0] buf_mask_q;
    logic [DW-1:0] diff_mask;
    logic          changed;
    logic          done;

    assign diff_mask = wr_data ^ cells[wr_row];
    assign changed   = |diff_mask;
    assign done      = (state_q == SB_PROGRAM) && (cnt_q == '0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SB_IDLE:    if (wr_go && changed) state_d = SB_PROGRAM;
            SB_PROGRAM: if (cnt_q == '0)      state_d = SB_IDLE;
            default:                          state_d = SB_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= SB_IDLE;
        else     state_q <= state_d;
    end

    // buffer, countdown and cell array
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            for (int i = 0; i < ROWS; i++) cells[i] <= '0;
        end else begin
            if (state_q == SB_IDLE && wr_go && changed) begin
                buf_row_q  <= wr_row;
                buf_data_q <= wr_data;
                buf_mask_q <= diff_mask;
                cnt_q      <= CW'(WR_LAT - 1);
            end else if (state_q == SB_PROGRAM && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (done)
                cells[buf_row_q] <= (cells[buf_row_q] & ~buf_mask_q)
                                  | (buf_data_q & buf_mask_q);
        end
    end

    // outputs: status and forwarding read port
    always_comb begin
        busy = (state_q == SB_PROGRAM);
        if (wr_go && wr_row == rd_row)
            rd_data = wr_data;
        else if (state_q == SB_PROGRAM && buf_row_q == rd_row)
            rd_data = buf_data_q;
        else
            rd_data = cells[rd_row];
    end

    a_r6_write_only_when_free: assert property (@(posedge clk) disable iff (rst)
        wr_go |-> state_q == SB_IDLE);

    a_r2_buffer_held: assert property (@(posedge clk) disable iff (rst)
        (state_q == SB_PROGRAM && !done) |=> busy && $stable(buf_row_q) && $stable(buf_data_q));

    a_r3_commit_lands: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(rst)) |-> cells[$past(buf_row_q)] == $past(buf_data_q));

    a_r7_null_write_idle: assert property (@(posedge clk) disable iff (rst)
        (wr_go && !changed) |=> !busy);

    a_r10_reset_idle: assert property (@(posedge clk)
        rst |=> !busy);
endmodule

// File: rtl/sw_req_port.sv
module sw_req_port #(
    parameter int AW  = 8,
    parameter int DW  = 16,
    parameter int NSB = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_wr_en,
    input  logic [AW-1:0]     req_wr_addr,
    input  logic              req_rd_en,
    input  logic [AW-1:0]     req_rd_addr,
    input  logic [NSB-1:0]    sb_busy,
    input  logic [NSB*DW-1:0] sb_rd_data,
    output logic              req_ready,
    output logic [NSB-1:0]    wr_go,
    output logic              rsp_valid,
    output logic [DW-1:0]     rsp_data
);
    localparam int SBW = $clog2(NSB);

    logic [SBW-1:0] wr_sb, rd_sb;
    logic           accept;

    assign wr_sb     = req_wr_addr[SBW-1:0];
    assign rd_sb     = req_rd_addr[SBW-1:0];
    assign req_ready = !(req_wr_en && sb_busy[wr_sb]);
    assign accept    = req_valid && req_ready;

    for (genvar g = 0; g < NSB; g++) begin : g_go
        assign wr_go[g] = accept && req_wr_en && (wr_sb == SBW'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= accept && req_rd_en;
            if (accept && req_rd_en)
                rsp_data <= sb_rd_data[rd_sb*DW +: DW];
        end
    end

    a_r6_stall_on_busy: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_wr_en && sb_busy[wr_sb]) |-> !req_ready && $countones(wr_go) == 0);

    a_r1_single_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_go));

    a_r8_rsp_has_cause: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && req_ready && req_rd_en));

    a_r8_rsp_follows: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_rd_en) |=> rsp_valid);
endmodule

// File: rtl/sw_subbank_ram.sv
module sw_subbank_ram #(
    parameter int DW     = 16,
    parameter int AW     = 8,
    parameter int NSB    = 4,
    parameter int WR_LAT = 20
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic           req_wr_en,
    input  logic [AW-1:0]  req_wr_addr,
    input  logic [DW-1:0]  req_wr_data,
    input  logic           req_rd_en,
    input  logic [AW-1:0]  req_rd_addr,
    output logic           rsp_valid,
    output logic [DW-1:0]  rsp_data,
    output logic [NSB-1:0] sb_busy
);
    localparam int SBW  = $clog2(NSB);
    localparam int RW   = AW - SBW;
    localparam int ROWS = 2 ** RW;

    logic [NSB-1:0]    wr_go;
    logic [NSB*DW-1:0] sb_rd_data;
    logic [RW-1:0]     wr_row, rd_row;

    assign wr_row = req_wr_addr[AW-1:SBW];
    assign rd_row = req_rd_addr[AW-1:SBW];

    sw_req_port #(.AW(AW), .DW(DW), .NSB(NSB)) u_port (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_wr_en  (req_wr_en),
        .req_wr_addr(req_wr_addr),
        .req_rd_en  (req_rd_en),
        .req_rd_addr(req_rd_addr),
        .sb_busy    (sb_busy),
        .sb_rd_data (sb_rd_data),
        .req_ready  (req_ready),
        .wr_go      (wr_go),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data)
    );

    for (genvar s = 0; s < NSB; s++) begin : g_sb
        sw_subbank_cell #(.DW(DW), .ROWS(ROWS), .WR_LAT(WR_LAT)) u_sb (
            .clk    (clk),
            .rst    (rst),
            .wr_go  (wr_go[s]),
            .wr_row (wr_row),
            .wr_data(req_wr_data),
            .rd_row (rd_row),
            .rd_data(sb_rd_data[s*DW +: DW]),
            .busy   (sb_busy[s])
        );
    end

    a_r9_same_cycle_forward: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_rd_en && req_wr_en && req_rd_addr == req_wr_addr)
        |=> rsp_data == $past(req_wr_data));
endmodule

// File: tb/tb_sw_subbank_ram.sv
module tb_sw_subbank_ram;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16, AW = 8, NSB = 4, WR_LAT = 20;
    localparam int NADDR = 2 ** AW;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           req_valid = 1'b0, req_wr_en = 1'b0, req_rd_en = 1'b0;
    logic [AW-1:0]  req_wr_addr = '0, req_rd_addr = '0;
    logic [DW-1:0]  req_wr_data = '0;
    logic           req_ready, rsp_valid;
    logic [DW-1:0]  rsp_data;
    logic [NSB-1:0] sb_busy;

    int checks = 0, errors = 0;
    logic [DW-1:0] exp_mem [NADDR];

    always #(CLK_PERIOD / 2) clk = ~clk;

    sw_subbank_ram #(.DW(DW), .AW(AW), .NSB(NSB), .WR_LAT(WR_LAT)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_wr_en(req_wr_en), .req_wr_addr(req_wr_addr), .req_wr_data(req_wr_data),
        .req_rd_en(req_rd_en), .req_rd_addr(req_rd_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .sb_busy(sb_busy)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // called at a negedge; returns at the negedge after acceptance
    task automatic issue(input logic wr, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                         input logic rd, input logic [AW-1:0] ra,
                         output int stalls, output logic gv, output logic [DW-1:0] gd);
        req_valid = 1'b1; req_wr_en = wr; req_wr_addr = wa; req_wr_data = wd;
        req_rd_en = rd; req_rd_addr = ra;
        #1;
        stalls = 0;
        while (!req_ready) begin
            stalls++;
            @(negedge clk); #1;
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_wr_en = 1'b0; req_rd_en = 1'b0;
        gv = rsp_valid; gd = rsp_data;
        if (wr) exp_mem[wa] = wd;
    endtask

    task automatic wait_idle();
        while (sb_busy != '0) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired (all requirements)");
        finish_run();
    end

    initial begin
        int st, cnt;
        logic gv;
        logic [DW-1:0] gd, d;
        logic [AW-1:0] a, o;
        for (int i = 0; i < NADDR; i++) exp_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R10: reset state
        chk(req_ready == 1'b1, "R10 ready after reset", 32'(req_ready), 1);
        chk(sb_busy == '0, "R10 busy after reset", 32'(sb_busy), 0);
        chk(rsp_valid == 1'b0, "R10 rsp_valid after reset", 32'(rsp_valid), 0);
        @(negedge clk);

        // R7: zero onto a cleared word changes nothing
        issue(1'b1, 8'd5, '0, 1'b0, '0, st, gv, gd);
        chk(sb_busy == '0, "R7 null write busy", 32'(sb_busy), 0);
        chk(gv == 1'b0, "R8 no rsp after write-only", 32'(gv), 0);
        issue(1'b0, '0, '0, 1'b1, 8'd5, st, gv, gd);
        chk(gv && gd == '0, "R10 array cleared / R7 word unchanged", 32'(gd), 0);

        // R1 / R2: back-to-back writes to distinct subbanks overlap
        for (int s = 0; s < NSB; s++) begin
            issue(1'b1, AW'(16 + s), DW'(16'hA100 + s), 1'b0, '0, st, gv, gd);
            chk(st == 0, "R1 no stall across subbanks", 32'(st), 0);
        end
        chk(sb_busy == '1, "R2 busy windows overlap", 32'(sb_busy), 32'hF);
        wait_idle();

        // R2: exact busy length; R3: data after commit
        issue(1'b1, 8'd6, 16'h5EED, 1'b0, '0, st, gv, gd);
        cnt = 0;
        while (sb_busy[2]) begin cnt++; @(negedge clk); end
        chk(cnt == WR_LAT, "R2 busy length", 32'(cnt), WR_LAT);
        issue(1'b0, '0, '0, 1'b1, 8'd6, st, gv, gd);
        chk(gv && gd == 16'h5EED, "R3 read after commit", 32'(gd), 32'h5EED);

        // sweep: forwarding (R4), other-row read under busy (R5), latency (R8)
        for (int i = 0; i < NADDR; i++) begin
            a = AW'(i);
            o = a ^ 8'h40;
            d = {~a, a ^ 8'h3C};
            issue(1'b1, a, d, 1'b0, '0, st, gv, gd);
            chk(sb_busy[a[1:0]] == 1'b1, "R2 busy after changing write", 32'(sb_busy), 32'(1 << a[1:0]));
            issue(1'b0, '0, '0, 1'b1, a, st, gv, gd);
            chk(gv && gd == d, "R4 forward from buffer", 32'(gd), 32'(d));
            issue(1'b0, '0, '0, 1'b1, o, st, gv, gd);
            chk(st == 0, "R5 read not stalled by busy subbank", 32'(st), 0);
            chk(gv && gd == exp_mem[o], "R5 other row data", 32'(gd), 32'(exp_mem[o]));
            @(negedge clk); #1;
            chk(rsp_valid == 1'b0, "R8 single-cycle pulse", 32'(rsp_valid), 0);
        end
        wait_idle();
        for (int i = 0; i < NADDR; i++) begin
            issue(1'b0, '0, '0, 1'b1, AW'(i), st, gv, gd);
            chk(gv && gd == exp_mem[i], "R3 array after sweep", 32'(gd), 32'(exp_mem[i]));
        end

        // R6 / R1 subbank decode: same subbank conflict stalls WR_LAT cycles
        issue(1'b1, 8'd8, 16'h1234, 1'b0, '0, st, gv, gd);
        issue(1'b1, 8'd12, 16'hBEEF, 1'b1, 8'd8, st, gv, gd);
        chk(st == WR_LAT, "R6 stall length on conflict", 32'(st), WR_LAT);
        chk(gv && gd == 16'h1234, "R6 bundled read after release", 32'(gd), 32'h1234);
        wait_idle();
        issue(1'b0, '0, '0, 1'b1, 8'd12, st, gv, gd);
        chk(gd == 16'hBEEF, "R6 stalled write lands", 32'(gd), 32'hBEEF);

        // R9: read and write same address together
        issue(1'b1, 8'd33, 16'hC0DE, 1'b1, 8'd33, st, gv, gd);
        chk(gv && gd == 16'hC0DE, "R9 same-cycle forward", 32'(gd), 32'hC0DE);
        wait_idle();

        // R7: rewrite of the stored value
        issue(1'b1, 8'd33, 16'hC0DE, 1'b0, '0, st, gv, gd);
        chk(sb_busy == '0, "R7 rewrite same value", 32'(sb_busy), 0);
        issue(1'b0, '0, '0, 1'b1, 8'd33, st, gv, gd);
        chk(gd == 16'hC0DE, "R7 value kept", 32'(gd), 32'hC0DE);

        finish_run();
    end
endmodule